// File: doc/BRIEF.md
# Gated Event Counter with Selectable Gate Source

This block is a 16-bit up-counter that advances on a clock enable (`tick`) only while a gate condition holds. The gate comes from one of four sources: an external pin, a one-cycle pulse from a built-in 8-bit period timer, or one of two comparator result bits. A polarity bit picks which level of the source lets the counter run. An optional toggle stage turns successive rising edges of the gate into alternate open and closed windows, so the counter measures a whole source period rather than one level.

Software-style control goes through one 8-bit control register and one period register. The current effective gate is readable as a status bit. The counter, the period timer's count and its period register are visible on output ports.

Top module: `gate_ctr`

## Requirements
- R1: Control bits [1:0] select the gate source: 00 the external pin after a two-flop synchronizer, 01 the period timer's match pulse, 10 comparator input 1, 11 comparator input 2.
- R2: Control bit 6 sets polarity. With 1, a high source level opens the gate. With 0, a low level opens it. This applies to every source.
- R3: On each `tick`, the period timer increments until it equals the period register. On the next `tick` it returns to 0. After reset the period register is FFh, and a write on `perWe` updates it.
- R4: The match pulse rises when the period timer returns to 0 and stays high for exactly one `tick` interval. It changes only on a `tick`.
- R5: With source 01 and polarity 1, the counter advances only in the tick interval after each timer wrap. With polarity 0, it advances in every tick interval except that one.
- R6: With control bit 5 (toggle) set, a flip-flop inverts on each rising edge of the polarity-adjusted gate. The flip-flop output becomes the gate, so the counter runs for one full source period and then pauses for the next.
- R7: While the toggle bit is clear, the toggle flip-flop is cleared and held at 0. After the bit is set again, the gate stays closed until the next rising edge of the gate.
- R8: Read bit 2 reports the effective gate state: the toggle flip-flop when toggle is set, otherwise the polarity-adjusted source. Writes to bit 2 have no effect. Bits 4:3 read as 0.
- R9: When control bit 7 (gate enable) is clear, the counter advances on every `tick`, whatever the gate state.
- R10: The counter changes only on a `tick` and only by +1. Reset clears the counter, the period timer, the match pulse and the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count clock enable |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 8 | Control register write data |
| perWe | input | 1 | Period register write strobe |
| perWdata | input | 8 | Period register write data |
| gatePin | input | 1 | External gate pin (asynchronous) |
| cmp1 | input | 1 | Comparator 1 result |
| cmp2 | input | 1 | Comparator 2 result |
| ctrlRdata | output | 8 | Control register read value, including gate status in bit 2 |
| gateVal | output | 1 | Effective gate state |
| count | output | 16 | Gated counter value |
| tmrCount | output | 8 | Period timer count |
| period | output | 8 | Period register |

## Verification
Two events can land on the same clock edge:
- the period timer wrapping, which produces a match pulse;
- a control write that changes source, polarity or toggle mode.

A rising gate edge can also meet a toggle-enable change on the same edge. The bench provokes these overlaps by writing new control values while the timer and the pin keep running freely, with `tick` dropped at random. On every clock, a behavioural model judges whether the counter advanced by the gate state in force before the write took effect.

// File: rtl/gate_ctr_pkg.sv
package gate_ctr_pkg;
  localparam int CTRL_W  = 8;
  localparam int BIT_GEN = 7;
  localparam int BIT_POL = 6;
  localparam int BIT_TGL = 5;
  localparam int BIT_VAL = 2;

  typedef struct packed {
    logic cntInc;
    logic tmrStep;
  } ctrStrobe_t;
endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : gStage
    if (i == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) sr[0] <= 1'b0;
        else       sr[0] <= din;
    end else begin : gRest
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) sr[i] <= 1'b0;
        else       sr[i] <= sr[i-1];
    end
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import gate_ctr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              gatePin,
  input  logic              cmp1,
  input  logic              cmp2,
  input  logic              matchPulse,
  output ctrStrobe_t        strobe,
  output logic [CTRL_W-1:0] ctrlRdata,
  output logic              gateVal
);
  logic [1:0] srcSel;
  logic       polBit, tglEn, gateEnBit;
  logic       pinSync, srcRaw, gateLvl, gatePrev, gateRise, tglFf, effGate;
  logic [2:0] unusedWr;

  assign unusedWr = ctrlWdata[4:2];

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel    <= 2'b00;
      polBit    <= 1'b0;
      tglEn     <= 1'b0;
      gateEnBit <= 1'b0;
    end else if (ctrlWe) begin
      srcSel    <= ctrlWdata[1:0];
      polBit    <= ctrlWdata[BIT_POL];
      tglEn     <= ctrlWdata[BIT_TGL];
      gateEnBit <= ctrlWdata[BIT_GEN];
    end
  end

  gate_sync #(.STAGES(SYNC_STAGES)) uPinSync (
    .clk(clk), .rstN(rstN), .din(gatePin), .dout(pinSync)
  );

  always_comb begin
    unique case (srcSel)
      2'b00:   srcRaw = pinSync;
      2'b01:   srcRaw = matchPulse;
      2'b10:   srcRaw = cmp1;
      default: srcRaw = cmp2;
    endcase
  end

  assign gateLvl  = polBit ? srcRaw : ~srcRaw;
  assign gateRise = gateLvl & ~gatePrev;

  // toggle flip-flop, held clear while toggle mode is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gatePrev <= 1'b0;
      tglFf    <= 1'b0;
    end else begin
      gatePrev <= gateLvl;
      tglFf    <= tglEn ? (tglFf ^ gateRise) : 1'b0;
    end
  end

  assign effGate        = tglEn ? tglFf : gateLvl;
  assign gateVal        = effGate;
  assign strobe.tmrStep = tick;
  assign strobe.cntInc  = tick & (~gateEnBit | effGate);

  always_comb begin
    ctrlRdata          = '0;
    ctrlRdata[1:0]     = srcSel;
    ctrlRdata[BIT_VAL] = effGate;
    ctrlRdata[BIT_TGL] = tglEn;
    ctrlRdata[BIT_POL] = polBit;
    ctrlRdata[BIT_GEN] = gateEnBit;
  end

  assert_tgl_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    !tglEn |=> !tglFf);

  assert_tgl_flip_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tglEn && gateRise) |=> (tglFf != $past(tglFf)));

  assert_free_run_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!gateEnBit && tick) |-> strobe.cntInc);

  assert_tick_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    !tick |-> !strobe.cntInc);
endmodule

// File: rtl/gate_dp.sv
module gate_dp
  import gate_ctr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrStrobe_t       strobe,
  input  logic             perWe,
  input  logic [TMR_W-1:0] perWdata,
  output logic [CNT_W-1:0] count,
  output logic [TMR_W-1:0] tmrCount,
  output logic [TMR_W-1:0] period,
  output logic             matchPulse
);
  logic tmrHit;
  assign tmrHit = (tmrCount == period);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      period <= '1;
    else if (perWe) period <= perWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCount   <= '0;
      matchPulse <= 1'b0;
    end else if (strobe.tmrStep) begin
      tmrCount   <= tmrHit ? '0 : tmrCount + TMR_W'(1);
      matchPulse <= tmrHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (strobe.cntInc) count <= count + CNT_W'(1);
  end

  assert_tmr_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tmrStep && tmrCount == period) |=> (tmrCount == '0));

  assert_tmr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tmrStep && tmrCount != period) |=> (tmrCount == $past(tmrCount) + TMR_W'(1)));

  assert_pulse_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchPulse) |-> (tmrCount == '0));

  assert_pulse_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tmrStep |=> $stable(matchPulse));

  assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cntInc |=> $stable(count));

  assert_cnt_inc_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntInc |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/gate_ctr.sv
module gate_ctr
  import gate_ctr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TMR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              perWe,
  input  logic [TMR_W-1:0]  perWdata,
  input  logic              gatePin,
  input  logic              cmp1,
  input  logic              cmp2,
  output logic [CTRL_W-1:0] ctrlRdata,
  output logic              gateVal,
  output logic [CNT_W-1:0]  count,
  output logic [TMR_W-1:0]  tmrCount,
  output logic [TMR_W-1:0]  period
);
  ctrStrobe_t strobe;
  logic       matchPulse;

  gate_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .gatePin(gatePin), .cmp1(cmp1), .cmp2(cmp2),
    .matchPulse(matchPulse), .strobe(strobe),
    .ctrlRdata(ctrlRdata), .gateVal(gateVal)
  );

  gate_dp #(.CNT_W(CNT_W), .TMR_W(TMR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .perWe(perWe), .perWdata(perWdata),
    .count(count), .tmrCount(tmrCount), .period(period),
    .matchPulse(matchPulse)
  );
endmodule

// File: tb/sim_gate_ctr.sv
`timescale 1ns/1ps
module sim_gate_ctr;
  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0;
  logic ctrlWe = 1'b0, perWe = 1'b0;
  logic [7:0] ctrlWdata = '0, perWdata = '0;
  logic gatePin = 1'b0, cmp1 = 1'b0, cmp2 = 1'b0;
  logic [7:0] ctrlRdata, tmrCount, period;
  logic gateVal;
  logic [15:0] count;

  int tests = 0, fails = 0;
  bit chkOn = 1'b0, done = 1'b0;
  string curReq = "R10";

  always #2 clk = ~clk;

  gate_ctr u0 (
    .clk(clk), .rstN(rstN), .tick(tick),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .perWe(perWe), .perWdata(perWdata),
    .gatePin(gatePin), .cmp1(cmp1), .cmp2(cmp2),
    .ctrlRdata(ctrlRdata), .gateVal(gateVal),
    .count(count), .tmrCount(tmrCount), .period(period)
  );

  // behavioural reference state
  logic [15:0] mCnt;
  logic [7:0]  mTmr, mPer;
  logic [1:0]  mSel;
  logic mPulse, mPol, mTgl, mGen, mTff, mPrev, mS1, mS2;

  function automatic logic mLevel();
    logic s;
    case (mSel)
      2'd0: s = mS2;
      2'd1: s = mPulse;
      2'd2: s = cmp1;
      default: s = cmp2;
    endcase
    return mPol ? s : !s;
  endfunction

  function automatic logic mEff();
    return mTgl ? mTff : mLevel();
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mTmr = 0; mPer = 8'hFF; mSel = 0; mPulse = 0;
      mPol = 0; mTgl = 0; mGen = 0; mTff = 0; mPrev = 0; mS1 = 0; mS2 = 0;
    end else begin
      logic lvl, eff;
      lvl = mLevel();
      eff = mEff();
      if (tick && (!mGen || eff)) mCnt = mCnt + 16'd1;
      mTff = mTgl ? (mTff ^ (lvl && !mPrev)) : 1'b0;
      mPrev = lvl;
      if (tick) begin
        if (mTmr == mPer) begin mTmr = 0; mPulse = 1; end
        else begin mTmr = mTmr + 8'd1; mPulse = 0; end
      end
      if (perWe) mPer = perWdata;
      mS2 = mS1; mS1 = gatePin;
      if (ctrlWe) begin
        mSel = ctrlWdata[1:0]; mPol = ctrlWdata[6];
        mTgl = ctrlWdata[5];   mGen = ctrlWdata[7];
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (chkOn && !done) begin
      chk(curReq, count, mCnt);
      chk("R3 timer", tmrCount, mTmr);
      chk("R3 period", period, mPer);
      chk("R8 readback", ctrlRdata, {mGen, mPol, mTgl, 2'b00, mEff(), mSel});
      chk("R8 gateVal", gateVal, mEff());
    end
  end

  task automatic step(input int n, input int pinRate, input bit tickRand, input bit cmpRand);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      ctrlWe = 0; perWe = 0;
      if (pinRate != 0 && ($urandom % pinRate) == 0) gatePin = ~gatePin;
      tick = tickRand ? (($urandom % 4) != 0) : 1'b1;
      if (cmpRand) begin
        if (($urandom % 5) == 0) cmp1 = ~cmp1;
        if (($urandom % 5) == 0) cmp2 = ~cmp2;
      end
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); #1;
    ctrlWe = 1; ctrlWdata = v;
  endtask

  task automatic wrPer(input logic [7:0] v);
    @(negedge clk); #1;
    perWe = 1; perWdata = v;
  endtask

  initial begin
    logic [15:0] c0;
    repeat (3) @(negedge clk);
    // R10: reset state; default source low with polarity 0 reads as open
    chk("R10 count", count, 0);
    chk("R10 timer", tmrCount, 0);
    chk("R3 reset period", period, 8'hFF);
    chk("R10 ctrl", ctrlRdata, 8'h04);
    #1 rstN = 1; chkOn = 1;

    curReq = "R9";  wr(8'h00); step(300, 5, 1, 0);
    curReq = "R1";  wr(8'hC0); step(300, 6, 1, 0);
    curReq = "R2";  wr(8'h80); step(300, 6, 1, 0);
    curReq = "R5";  wrPer(8'd3); wr(8'hC1); step(200, 0, 0, 0);
    wr(8'h81); step(200, 0, 0, 0);
    curReq = "R4";  wrPer(8'd5); wr(8'hC1); step(300, 0, 1, 0);
    curReq = "R1";  wr(8'hC2); step(200, 0, 1, 1); wr(8'h83); step(200, 0, 1, 1);
    curReq = "R6";  wr(8'hE0); step(400, 7, 1, 0); wr(8'hE1); step(300, 0, 1, 0);
    wr(8'hA2); step(300, 0, 1, 1);

    // R7: re-arming toggle with a steady high gate leaves the window closed
    curReq = "R7";
    @(negedge clk); #1; gatePin = 1;
    wr(8'hC0); step(5, 0, 0, 0);
    wr(8'hE0); step(5, 0, 0, 0);
    chk("R7 status", ctrlRdata[2], 0);
    c0 = count;
    step(6, 0, 0, 0);
    chk("R7 count held", count, c0);

    // R8: writing bit 2 has no effect on the status read
    curReq = "R8";
    @(negedge clk); #1; gatePin = 0;
    step(4, 0, 0, 0);
    wr(8'h44); step(4, 0, 0, 0);
    chk("R8 status write ignored", ctrlRdata, 8'h40);

    step(2, 0, 0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule